// File: doc/BRIEF.md
# Page-Mode DRAM Controller with CBR Refresh

This block lets a synchronous host read and write a 1M x 16 asynchronous extended-data-out DRAM. The host presents one request at a time through a valid/ready handshake: a 20-bit word address, a write flag, a 16-bit write word and two byte enables. Read words come back on a data output qualified by a one-cycle valid strobe, in request order.

On the memory side the controller produces the active-low row strobe, two active-low column strobes (one per byte lane), write enable and output enable. It also drives a 10-bit address bus that carries first the row half and then the column half of the host address, and a split data bus (out, in, output enable). Back-to-back requests to the row that is already open are served in page mode, without closing the row. A free-running interval timer raises a refresh request. The request is served as a column-before-row refresh once the access in flight has finished, ahead of any waiting host request. After reset the block waits a programmable power-up time and runs a fixed number of refresh cycles before it first offers ready.

All memory timing (row-to-column delay, read column width, write column width, column precharge, row precharge, refresh setup and refresh row width) is set in whole clock cycles by parameters.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The row address `host_addr[19:10]` is on `dram_addr` when the row strobe falls. The column address `host_addr[9:0]` is on `dram_addr` when a column strobe falls and stays unchanged while both row and column strobes are low.
- R2: For a write, `host_be[0]` selects `dram_cas_l_n` (data bits 7:0) and `host_be[1]` selects `dram_cas_h_n` (bits 15:8). A lane whose enable is 0 keeps its stored byte.
- R3: For reads and for writes with both enables set, the two column strobes fall on the same clock edge and are low together.
- R4: After initialisation, no more than `REF_INTERVAL` + 25 clock cycles pass between consecutive refresh cycles.
- R5: A refresh cycle holds both column strobes low for at least one cycle before the row strobe falls, with write enable high.
- R6: Output enable is high whenever the controller drives the data bus, and it is high during writes.
- R7: For a write, write enable is already low in the cycle before a column strobe falls.
- R8: Each read returns, through one `host_rvalid` pulse per read and in request order, the word last written to that address (0 if never written). The word is sampled only after the row and column access times have elapsed.
- R9: Consecutive requests to the same row, with no refresh due, are served with a single fall of the row strobe.
- R10: During reset all strobes are high and ready is low. Ready first rises no sooner than `PWRUP_CYC` cycles after reset, and only after exactly `INIT_REFS` refresh cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Request accepted at this edge when valid |
| host_addr | input | 20 | Word address (row in 19:10, column in 9:0) |
| host_write | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 16 | Write word |
| host_be | input | 2 | Byte enables (bit 0 low byte, bit 1 high byte) |
| host_rdata | output | 16 | Read word |
| host_rvalid | output | 1 | One-cycle read data valid |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_l_n | output | 1 | Low-byte column strobe, active low |
| dram_cas_h_n | output | 1 | High-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data to memory |
| dram_dq_in | input | 16 | Data from memory |
| dram_dq_oe | output | 1 | Controller drives the data bus |

## Verification
A sequencer stuck in, or jumping to, the wrong state shows up at the next strobe edge. Examples are a lone column strobe during a word access, write enable rising after the column strobe, or the row strobe falling before the column strobes in a refresh. The bench catches each of these in the same cycle, because its memory model watches every edge. A wrong latched address or lane mask stays hidden until the word is read back, so the bench checks the address at each strobe fall, and read data is compared when `host_rvalid` pulses. A lost refresh request only becomes visible as a gap between refresh cycles that grows past the interval bound. A lost read becomes visible when the read queue fails to drain at the end of the run.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;
    localparam int ROW_W  = 10;
    localparam int COL_W  = 10;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int DATA_W = 16;
    localparam int LANES  = 2;

    typedef enum logic [3:0] {
        ST_PWRUP, ST_IDLE, ST_ROW, ST_COL, ST_CASPRE,
        ST_PSET, ST_PRE, ST_RCAS, ST_RRAS, ST_RPRE
    } edo_state_e;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
    } edo_req_t;

    typedef struct packed {
        logic ras_n;
        logic cas_l_n;
        logic cas_h_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } edo_pins_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic edo_req_t make_req(input logic [ADDR_W-1:0] a, input logic wr,
                                          input logic [LANES-1:0] be,
                                          input logic [DATA_W-1:0] d);
        edo_req_t r;
        r.row   = a[ADDR_W-1:COL_W];
        r.col   = a[COL_W-1:0];
        r.wr    = wr;
        r.be    = be;
        r.wdata = d;
        return r;
    endfunction
endpackage

// File: rtl/edo_ref_timer.sv
`timescale 1ns/1ps
module edo_ref_timer #(
    parameter int REF_INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_ack,
    output logic ref_pending
);
    localparam int RW = $clog2(REF_INTERVAL + 1);

    logic [RW-1:0] cnt;
    logic          expire;

    assign expire = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= RW'(REF_INTERVAL - 1);
            ref_pending <= 1'b0;
        end else begin
            cnt         <= expire ? RW'(REF_INTERVAL - 1) : cnt - 1'b1;
            ref_pending <= expire | (ref_pending & ~ref_ack);
        end
    end

    // R4: a served refresh request is dropped unless a new one arrives at once
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (ref_ack && !expire) |=> !ref_pending);
endmodule

// File: rtl/edo_seq.sv
`timescale 1ns/1ps
module edo_seq
    import edo_pkg::*;
#(
    parameter int PWRUP_CYC = 20000,
    parameter int INIT_REFS = 8,
    parameter int T_RCD     = 2,
    parameter int T_RD      = 4,
    parameter int T_WR      = 2,
    parameter int T_CP      = 1,
    parameter int T_RP      = 4,
    parameter int T_CSR     = 1,
    parameter int T_RAS     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_valid,
    input  edo_req_t          host_req,
    output logic              host_ready,
    input  logic              ref_pending,
    output logic              ref_ack,
    output edo_pins_t         pins,
    output logic [ROW_W-1:0]  addr,
    output logic [DATA_W-1:0] dq_out,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int MAXD = max_of(PWRUP_CYC, max_of(max_of(T_RCD, T_RD),
                          max_of(max_of(T_WR, T_CP), max_of(T_RP, max_of(T_CSR, T_RAS)))));
    localparam int CW = $clog2(MAXD + 1);
    localparam int IW = $clog2(INIT_REFS + 1);

    edo_state_e    state, state_nxt;
    edo_req_t      cur, cur_nxt;
    logic [CW-1:0] cnt;
    logic [IW-1:0] init_left, init_nxt;
    logic          last, init_done, idle_go, page_go, accept;

    function automatic logic [CW-1:0] dur(input edo_state_e s, input logic wr);
        int d;
        case (s)
            ST_PWRUP:  d = PWRUP_CYC;
            ST_ROW:    d = T_RCD;
            ST_COL:    d = wr ? T_WR : T_RD;
            ST_CASPRE: d = T_CP;
            ST_PRE:    d = T_RP;
            ST_RCAS:   d = T_CSR;
            ST_RRAS:   d = T_RAS;
            ST_RPRE:   d = T_RP;
            default:   d = 1;
        endcase
        return CW'(d - 1);
    endfunction

    assign last      = (cnt == '0);
    assign init_done = (init_left == '0);
    assign idle_go   = (state == ST_IDLE) && init_done && !ref_pending;
    assign page_go   = (state == ST_CASPRE) && last && !ref_pending && (host_req.row == cur.row);
    assign host_ready = idle_go || page_go;
    assign accept    = host_valid && host_ready;
    assign ref_ack   = (state == ST_IDLE) && init_done && ref_pending;

    always_comb begin
        state_nxt = state;
        cur_nxt   = cur;
        init_nxt  = init_left;
        if (accept) cur_nxt = host_req;
        case (state)
            ST_PWRUP:  if (last) state_nxt = ST_RCAS;
            ST_IDLE: begin
                if (ref_ack)     state_nxt = ST_RCAS;
                else if (accept) state_nxt = ST_ROW;
            end
            ST_ROW:    if (last) state_nxt = ST_COL;
            ST_COL:    if (last) state_nxt = ST_CASPRE;
            ST_CASPRE: if (last) state_nxt = accept ? ST_PSET : ST_PRE;
            ST_PSET:   state_nxt = ST_COL;
            ST_PRE:    if (last) state_nxt = ST_IDLE;
            ST_RCAS:   if (last) state_nxt = ST_RRAS;
            ST_RRAS:   if (last) state_nxt = ST_RPRE;
            ST_RPRE: begin
                if (last) begin
                    if (init_left != '0) init_nxt = init_left - 1'b1;
                    state_nxt = (init_left > IW'(1)) ? ST_RCAS : ST_IDLE;
                end
            end
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_PWRUP;
            cnt       <= CW'(PWRUP_CYC - 1);
            cur       <= '0;
            init_left <= IW'(INIT_REFS);
        end else begin
            state     <= state_nxt;
            cur       <= cur_nxt;
            init_left <= init_nxt;
            if (state_nxt != state) cnt <= dur(state_nxt, cur_nxt.wr);
            else if (!last)         cnt <= cnt - 1'b1;
        end
    end

    // Strobe and bus decode from the current state
    always_comb begin
        pins   = '{ras_n: 1'b1, cas_l_n: 1'b1, cas_h_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        addr   = '0;
        dq_out = cur.wdata;
        case (state)
            ST_ROW: begin
                pins.ras_n = 1'b0;
                pins.we_n  = ~cur.wr;
                pins.dq_oe = cur.wr;
                addr       = cur.row;
            end
            ST_COL: begin
                pins.ras_n   = 1'b0;
                pins.cas_l_n = cur.wr ? ~cur.be[0] : 1'b0;
                pins.cas_h_n = cur.wr ? ~cur.be[1] : 1'b0;
                pins.we_n    = ~cur.wr;
                pins.oe_n    = cur.wr;
                pins.dq_oe   = cur.wr;
                addr         = cur.col;
            end
            ST_CASPRE, ST_PSET: begin
                pins.ras_n = 1'b0;
                pins.we_n  = ~cur.wr;
                pins.dq_oe = cur.wr;
                addr       = cur.col;
            end
            ST_RCAS: begin
                pins.cas_l_n = 1'b0;
                pins.cas_h_n = 1'b0;
            end
            ST_RRAS: begin
                pins.ras_n   = 1'b0;
                pins.cas_l_n = 1'b0;
                pins.cas_h_n = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= (state == ST_COL) && last && !cur.wr;
            if ((state == ST_COL) && last && !cur.wr) rdata <= dq_in;
        end
    end

    assert_no_bus_fight_R6: assert property (@(posedge clk) disable iff (rst)
        !(pins.dq_oe && !pins.oe_n));

    assert_cbr_order_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(pins.ras_n) && !pins.cas_l_n) |-> (!$past(pins.cas_l_n) && !$past(pins.cas_h_n) && pins.we_n));

    assert_early_write_R7: assert property (@(posedge clk) disable iff (rst)
        (($fell(pins.cas_l_n) || $fell(pins.cas_h_n)) && !pins.we_n) |-> !$past(pins.we_n));

    assert_lanes_together_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(pins.cas_l_n) && !pins.cas_h_n) |-> $fell(pins.cas_h_n));

    assert_col_addr_stable_R1: assert property (@(posedge clk) disable iff (rst)
        (!pins.ras_n && !pins.cas_l_n && $past(!pins.ras_n && !pins.cas_l_n)) |-> $stable(addr));
endmodule

// File: rtl/edo_dram_ctrl.sv
`timescale 1ns/1ps
module edo_dram_ctrl
    import edo_pkg::*;
#(
    parameter int PWRUP_CYC    = 20000,
    parameter int INIT_REFS    = 8,
    parameter int REF_INTERVAL = 1560,
    parameter int T_RCD        = 2,
    parameter int T_RD         = 4,
    parameter int T_WR         = 2,
    parameter int T_CP         = 1,
    parameter int T_RP         = 4,
    parameter int T_CSR        = 1,
    parameter int T_RAS        = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_valid,
    output logic        host_ready,
    input  logic [19:0] host_addr,
    input  logic        host_write,
    input  logic [15:0] host_wdata,
    input  logic [1:0]  host_be,
    output logic [15:0] host_rdata,
    output logic        host_rvalid,
    output logic        dram_ras_n,
    output logic        dram_cas_l_n,
    output logic        dram_cas_h_n,
    output logic        dram_we_n,
    output logic        dram_oe_n,
    output logic [9:0]  dram_addr,
    output logic [15:0] dram_dq_out,
    input  logic [15:0] dram_dq_in,
    output logic        dram_dq_oe
);
    edo_req_t  req;
    edo_pins_t pins;
    logic      ref_pending, ref_ack;

    assign req = make_req(host_addr, host_write, host_be, host_wdata);

    edo_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
        .clk(clk), .rst(rst), .ref_ack(ref_ack), .ref_pending(ref_pending)
    );

    edo_seq #(
        .PWRUP_CYC(PWRUP_CYC), .INIT_REFS(INIT_REFS), .T_RCD(T_RCD), .T_RD(T_RD),
        .T_WR(T_WR), .T_CP(T_CP), .T_RP(T_RP), .T_CSR(T_CSR), .T_RAS(T_RAS)
    ) u_seq (
        .clk(clk), .rst(rst), .host_valid(host_valid), .host_req(req),
        .host_ready(host_ready), .ref_pending(ref_pending), .ref_ack(ref_ack),
        .pins(pins), .addr(dram_addr), .dq_out(dram_dq_out), .dq_in(dram_dq_in),
        .rdata(host_rdata), .rvalid(host_rvalid)
    );

    assign dram_ras_n   = pins.ras_n;
    assign dram_cas_l_n = pins.cas_l_n;
    assign dram_cas_h_n = pins.cas_h_n;
    assign dram_we_n    = pins.we_n;
    assign dram_oe_n    = pins.oe_n;
    assign dram_dq_oe   = pins.dq_oe;
endmodule

// File: tb/edo_dram_ctrl_test.sv
`timescale 1ns/1ps
module edo_dram_ctrl_test;
    localparam int PWR = 20, IREF = 8, RINT = 300, SLACK = 25;

    logic clk = 1'b0, rst = 1'b1;
    always #5 clk = ~clk;

    logic        host_valid, host_ready, host_write, host_rvalid;
    logic [19:0] host_addr;
    logic [15:0] host_wdata, host_rdata, dram_dq_out, dram_dq_in;
    logic [1:0]  host_be;
    logic        dram_ras_n, dram_cas_l_n, dram_cas_h_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [9:0]  dram_addr;

    edo_dram_ctrl #(.PWRUP_CYC(PWR), .INIT_REFS(IREF), .REF_INTERVAL(RINT)) uut (
        .clk(clk), .rst(rst), .host_valid(host_valid), .host_ready(host_ready),
        .host_addr(host_addr), .host_write(host_write), .host_wdata(host_wdata),
        .host_be(host_be), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .dram_ras_n(dram_ras_n), .dram_cas_l_n(dram_cas_l_n), .dram_cas_h_n(dram_cas_h_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
        .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in), .dram_dq_oe(dram_dq_oe)
    );

    int compared = 0, mismatched = 0;
    int cyc = 0, ras_falls = 0, cbr_init = 0, cbr_total = 0, last_cbr = -1;
    bit seen_ready = 0;

    logic [15:0] mem [int];
    logic [15:0] shadow [int];
    logic [15:0] expq [$];
    logic [19:0] exp_addr = '0;
    logic        exp_wr = 1'b0;
    logic [1:0]  exp_be = 2'b11;
    logic [9:0]  m_row = '0, m_col = '0;
    time         t_ras = 0, t_cas = 0;
    logic        p_ras = 1'b1, p_cl = 1'b1, p_ch = 1'b1, p_we = 1'b1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000) begin
            mismatched++;
            $display("FAIL R8: watchdog actual %0d cycles expected < 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // Memory model and per-cycle protocol comparison
    always @(negedge clk) begin
        int idx;
        if (!rst) begin
            check(!(dram_dq_oe && !dram_oe_n), "R6 bus fight", {dram_dq_oe, dram_oe_n}, 32'h1);
            if (!dram_we_n) check(dram_oe_n, "R6 oe during write", dram_oe_n, 1);
            if (host_ready && !seen_ready) begin
                seen_ready = 1;
                check(cbr_init == IREF, "R10 init refresh count", cbr_init, IREF);
                check(cyc >= PWR, "R10 power-up wait", cyc, PWR);
            end
            if (p_ras && !dram_ras_n) begin
                if (!dram_cas_l_n || !dram_cas_h_n) begin
                    check(!p_cl && !p_ch && dram_we_n, "R5 CBR order", {p_cl, p_ch, dram_we_n}, 32'h1);
                    cbr_total++;
                    if (!seen_ready) cbr_init++;
                    else if (last_cbr >= 0)
                        check(cyc - last_cbr <= RINT + SLACK, "R4 refresh gap", cyc - last_cbr, RINT + SLACK);
                    if (seen_ready) last_cbr = cyc;
                end else begin
                    ras_falls++;
                    m_row = dram_addr;
                    t_ras = $time;
                    check(dram_addr == exp_addr[19:10], "R1 row address", dram_addr, exp_addr[19:10]);
                end
            end
            if (!dram_ras_n && p_cl && p_ch && (!dram_cas_l_n || !dram_cas_h_n)) begin
                m_col = dram_addr;
                t_cas = $time;
                check(dram_addr == exp_addr[9:0], "R1 column address", dram_addr, exp_addr[9:0]);
                if (exp_wr) begin
                    check({!dram_cas_h_n, !dram_cas_l_n} == exp_be, "R2 lane strobes",
                          {!dram_cas_h_n, !dram_cas_l_n}, exp_be);
                    check(!p_we, "R7 early write", p_we, 0);
                end else
                    check(!dram_cas_l_n && !dram_cas_h_n, "R3 read lanes",
                          {dram_cas_h_n, dram_cas_l_n}, 0);
                if (!dram_we_n) begin
                    idx = int'({m_row, m_col});
                    if (!mem.exists(idx)) mem[idx] = 16'h0;
                    if (!dram_cas_l_n) mem[idx][7:0]  = dram_dq_out[7:0];
                    if (!dram_cas_h_n) mem[idx][15:8] = dram_dq_out[15:8];
                end
            end
            if (dram_cas_l_n != dram_cas_h_n)
                check(exp_wr && exp_be != 2'b11, "R3 split lanes only on byte write", {exp_wr, exp_be}, 32'h5);
            idx = int'({m_row, m_col});
            if (!dram_ras_n && !dram_oe_n && (!dram_cas_l_n || !dram_cas_h_n) &&
                ($time - t_ras >= 50) && ($time - t_cas >= 15))
                dram_dq_in = mem.exists(idx) ? mem[idx] : 16'h0;
            else
                dram_dq_in = 16'hBAD0;
            if (host_rvalid) begin
                if (expq.size() == 0) check(0, "R8 unexpected read data", host_rdata, 0);
                else begin
                    logic [15:0] e;
                    e = expq.pop_front();
                    check(host_rdata == e, "R8 read data", host_rdata, e);
                end
            end
        end
        p_ras = dram_ras_n; p_cl = dram_cas_l_n; p_ch = dram_cas_h_n; p_we = dram_we_n;
    end

    task automatic issue(input logic [19:0] a, input bit wr, input logic [1:0] be, input logic [15:0] d);
        logic [15:0] old;
        host_valid = 1'b1; host_addr = a; host_write = wr; host_be = be; host_wdata = d;
        #1;
        while (!host_ready) begin @(negedge clk); #1; end
        exp_addr = a; exp_wr = wr; exp_be = be;
        old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
        if (wr) shadow[int'(a)] = {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
        else    expq.push_back(old);
        @(negedge clk);
    endtask

    task automatic idle();
        host_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [19:0] lfsr;
        int r0, c0;
        host_valid = 0; host_addr = 0; host_write = 0; host_wdata = 0; host_be = 0;
        dram_dq_in = 16'hBAD0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(dram_ras_n && dram_cas_l_n && dram_cas_h_n, "R10 strobes in reset",
              {dram_ras_n, dram_cas_l_n, dram_cas_h_n}, 32'h7);
        check(!host_ready && !host_rvalid, "R10 ready in reset", {host_ready, host_rvalid}, 0);
        rst = 0;
        while (!host_ready) @(negedge clk);

        // R8 word write and read back
        issue(20'h12345, 1, 2'b11, 16'hBEEF); idle();
        issue(20'h12345, 0, 2'b11, 16'h0);    idle();
        // R2 byte lanes
        issue(20'h0ABCD, 1, 2'b11, 16'h1234); idle();
        issue(20'h0ABCD, 1, 2'b10, 16'hAB00); idle();
        issue(20'h0ABCD, 0, 2'b11, 16'h0);    idle();
        issue(20'h0ABCD, 1, 2'b01, 16'hFFCD); idle();
        issue(20'h0ABCD, 0, 2'b11, 16'h0);    idle();
        repeat (20) @(negedge clk);

        // R9 page burst right after a refresh
        c0 = cbr_total;
        while (cbr_total == c0) @(negedge clk);
        repeat (20) @(negedge clk);
        r0 = ras_falls;
        for (int i = 0; i < 4; i++) issue({10'h155, 10'(i * 7)}, 1, 2'b11, 16'(16'hC000 + i));
        issue({10'h155, 10'd7}, 1, 2'b01, 16'h00EE);
        for (int i = 0; i < 4; i++) issue({10'h155, 10'(i * 7)}, 0, 2'b11, 16'h0);
        idle();
        repeat (10) @(negedge clk);
        check(ras_falls - r0 == 1, "R9 single row open for burst", ras_falls - r0, 1);

        // Mixed rows and lanes
        lfsr = 20'h5A5A5;
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[18:0], lfsr[19] ^ lfsr[16]};
            issue(lfsr, 1, lfsr[1:0] | 2'b01, lfsr[15:0] ^ 16'h3C3C);
            if (i % 3 == 0) idle();
            issue(lfsr, 0, 2'b11, 16'h0);
            if (i % 2 == 0) idle();
        end
        idle();

        // R4 refresh cadence while idle
        repeat (900) @(negedge clk);
        check(expq.size() == 0, "R8 all reads returned", expq.size(), 0);
        check(cyc - last_cbr <= RINT + SLACK, "R4 final refresh gap", cyc - last_cbr, RINT + SLACK);
        check(cbr_total > IREF + 3, "R4 periodic refreshes seen", cbr_total, IREF + 4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule